// File: doc/BRIEF.md
# Multi-Mode Quadrature Encoder Counter

This block turns the two phase signals of an incremental position encoder into a 16-bit signed-agnostic position count. Both phase pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer and then an edge detector. A decoder then turns the detected edges into up or down count events under one of four selectable schemes:

- **Phase-B sampling** (mode 0): a valid edge on phase A counts, and phase B sets the direction.
- **Split up/down** (mode 1): phase A edges count up and phase B edges count down.
- **A-gated by B** (mode 2): phase A edges count only while phase B is low.
- **Full 4x quadrature** (mode 3).

The counter wraps in both directions. A direction flag remembers the sense of the last count. A one-cycle match pulse fires when the updated count equals a compare value. An optional clear rule returns the counter to zero when a down count arrives while the counter sits on the compare value.

The 4x scheme is a four-state machine whose state is the last synchronized phase pair. The states are `GS_00`, `GS_10`, `GS_11` and `GS_01`. The forward transitions GS_00→GS_10, GS_10→GS_11, GS_11→GS_01 and GS_01→GS_00 count up. The reverse transitions GS_10→GS_00, GS_11→GS_10, GS_01→GS_11 and GS_00→GS_01 count down. Staying in a state counts nothing. The diagonal transitions GS_00↔GS_11 and GS_10↔GS_01 are illegal: they count nothing and set a sticky error flag. The machine follows the pins in every mode, so switching into mode 3 never sees a stale state.

Top module: `quad_enc_counter`

## Requirements
- R1: An input level change that is held is seen as exactly one edge event, and it changes `count` at the third rising clock edge after the change.
- R2: In mode 0 (`mode`=0), each valid phase-A edge counts down if the synchronized phase B is 1 and counts up if it is 0; phase-B edges alone never count.
- R3: In mode 1, a valid phase-A edge counts up and a valid phase-B edge counts down; if both arrive in the same cycle the count is unchanged.
- R4: In mode 2, a rising phase-A edge counts up and a falling phase-A edge counts down, only while phase B is 0; phase-A edges while B is 1, and all B edges, do not count.
- R5: In mode 3, the phase pair {A,B} stepping 00→10→11→01→00 counts up one per step, and the reverse order counts down one per step.
- R6: In mode 3, a change of both phases in the same cycle counts nothing and sets `enc_err`, which stays 1 until reset.
- R7: `a_edge_sel` and `b_edge_sel` use the encoding 0 = no edge, 1 = rising, 2 = falling, 3 = both, and they qualify the edges in modes 0 and 1; in modes 2 and 3 they are ignored and both edges are used.
- R8: The counter wraps modulo 2^16: up from 0xFFFF gives 0 and down from 0 gives 0xFFFF.
- R9: `dir_up` is 1 after an up count and 0 after a down count, and it is unchanged when no count occurs.
- R10: With `clr_mode`=1, a down count event that arrives while `count` equals `cmp_val` loads 0; with `clr_mode`=0 it decrements normally.
- R11: `match` is high for exactly the one cycle after a count event whose resulting count equals `cmp_val`, and low otherwise.
- R12: Synchronous reset `rst` sets `count` to 0, `dir_up` to 0, `match` to 0 and `enc_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| mode | input | 2 | Decoding scheme 0..3 |
| a_edge_sel | input | 2 | Valid-edge choice for phase A (modes 0 and 1) |
| b_edge_sel | input | 2 | Valid-edge choice for phase B (mode 1) |
| clr_mode | input | 1 | 1 enables clear of the counter on a down count at the compare value |
| cmp_val | input | 16 | Compare value |
| count | output | 16 | Current count |
| dir_up | output | 1 | Direction of the last count, 1 = up |
| match | output | 1 | One-cycle pulse: updated count equals compare value |
| enc_err | output | 1 | Sticky illegal 4x transition flag |

## Verification
The match assertion assumes that `cmp_val` does not change in the cycle that a count lands. The bench therefore writes the compare value only while the phase pins are idle, and lets the synchronizer settle before any new edge.

The edge and decode assertions assume that each phase level is held for at least one clock. The stimulus holds every phase level for four clocks and changes both pins together only where a simultaneous edge is the point of the test.

Configuration ports are also changed only while the pins are quiet. This way no mode switch lands on an edge in flight.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
package qenc_pkg;

    typedef enum logic [1:0] {
        MODE_BSAMPLE = 2'd0,
        MODE_SPLIT   = 2'd1,
        MODE_AGATED  = 2'd2,
        MODE_QUAD4   = 2'd3
    } qmode_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    // encoding equals the {A,B} level pair of the state
    typedef enum logic [1:0] {
        GS_00 = 2'b00,
        GS_01 = 2'b01,
        GS_10 = 2'b10,
        GS_11 = 2'b11
    } gray_st_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic lvl;
    } phase_t;

    function automatic logic edge_hit(input edge_sel_e sel, input phase_t ph);
        logic hit;
        unique case (sel)
            EDGE_OFF:  hit = 1'b0;
            EDGE_RISE: hit = ph.rise;
            EDGE_FALL: hit = ph.fall;
            EDGE_BOTH: hit = ph.rise | ph.fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/qenc_phase_sync.sv
`timescale 1ns/1ps
module qenc_phase_sync
    import qenc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin,
    output phase_t ph
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[LAST-1:0], pin};
            prev  <= chain[LAST];
        end
    end

    always_comb begin
        ph.lvl  = chain[LAST];
        ph.rise = chain[LAST] & ~prev;
        ph.fall = ~chain[LAST] & prev;
    end

    // R1
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ph.rise |=> !ph.rise);

    // R1
    single_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ph.fall |=> !ph.fall);

endmodule

// File: rtl/qenc_decode.sv
`timescale 1ns/1ps
module qenc_decode
    import qenc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  qmode_e    mode,
    input  edge_sel_e a_sel,
    input  edge_sel_e b_sel,
    input  phase_t    pa,
    input  phase_t    pb,
    output logic      step_up,
    output logic      step_dn,
    output logic      bad_step
);

    gray_st_e st_q, st_nx, lvl_st;
    logic     q_up, q_dn, q_bad;
    logic     a_hit, b_hit;

    assign lvl_st = gray_st_e'({pa.lvl, pb.lvl});

    // state register of the 4x machine
    always_ff @(posedge clk) begin
        if (rst) st_q <= GS_00;
        else     st_q <= st_nx;
    end

    // transition classification of the 4x machine
    always_comb begin
        st_nx = lvl_st;
        q_up  = 1'b0;
        q_dn  = 1'b0;
        q_bad = 1'b0;
        unique case (st_q)
            GS_00: begin
                if (lvl_st == GS_10)      q_up  = 1'b1;
                else if (lvl_st == GS_01) q_dn  = 1'b1;
                else if (lvl_st == GS_11) q_bad = 1'b1;
            end
            GS_10: begin
                if (lvl_st == GS_11)      q_up  = 1'b1;
                else if (lvl_st == GS_00) q_dn  = 1'b1;
                else if (lvl_st == GS_01) q_bad = 1'b1;
            end
            GS_11: begin
                if (lvl_st == GS_01)      q_up  = 1'b1;
                else if (lvl_st == GS_10) q_dn  = 1'b1;
                else if (lvl_st == GS_00) q_bad = 1'b1;
            end
            GS_01: begin
                if (lvl_st == GS_00)      q_up  = 1'b1;
                else if (lvl_st == GS_11) q_dn  = 1'b1;
                else if (lvl_st == GS_10) q_bad = 1'b1;
            end
            default: st_nx = GS_00;
        endcase
    end

    assign a_hit = edge_hit(a_sel, pa);
    assign b_hit = edge_hit(b_sel, pb);

    // output selection by decoding scheme
    always_comb begin
        step_up  = 1'b0;
        step_dn  = 1'b0;
        bad_step = 1'b0;
        unique case (mode)
            MODE_BSAMPLE: begin
                step_up = a_hit & ~pb.lvl;
                step_dn = a_hit &  pb.lvl;
            end
            MODE_SPLIT: begin
                step_up = a_hit & ~b_hit;
                step_dn = b_hit & ~a_hit;
            end
            MODE_AGATED: begin
                step_up = pa.rise & ~pb.lvl;
                step_dn = pa.fall & ~pb.lvl;
            end
            MODE_QUAD4: begin
                step_up  = q_up;
                step_dn  = q_dn;
                bad_step = q_bad;
            end
            default: ;
        endcase
    end

    // R6
    bad_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        bad_step |-> ((pa.rise | pa.fall) && (pb.rise | pb.fall)));

    // R4
    agated_block_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_AGATED && pb.lvl) |-> (!step_up && !step_dn));

    // R2
    bsample_b_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BSAMPLE && !pa.rise && !pa.fall) |-> (!step_up && !step_dn));

    // R3
    split_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step_up, step_dn}));

endmodule

// File: rtl/qenc_count_core.sv
`timescale 1ns/1ps
module qenc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up,
    input  logic             dn,
    input  logic             bad,
    input  logic             clr_en,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             match,
    output logic             err
);

    logic [CNT_W-1:0] cnt_nx;
    logic             at_cmp;
    logic             evt;

    assign at_cmp = (count == cmp);
    assign evt    = up | dn;

    always_comb begin
        cnt_nx = count;
        if (up)
            cnt_nx = count + CNT_W'(1);
        else if (dn)
            cnt_nx = (clr_en && at_cmp) ? '0 : count - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            dir_up <= 1'b0;
            match  <= 1'b0;
            err    <= 1'b0;
        end else begin
            count <= cnt_nx;
            match <= evt && (cnt_nx == cmp);
            err   <= err | bad;
            if (up)      dir_up <= 1'b1;
            else if (dn) dir_up <= 1'b0;
        end
    end

    // R8
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        up |=> count == CNT_W'($past(count) + CNT_W'(1)));

    // R8
    dn_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (dn && !(clr_en && at_cmp)) |=> count == CNT_W'($past(count) - CNT_W'(1)));

    // R10
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dn && clr_en && at_cmp) |=> count == '0);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!up && !dn) |=> ($stable(count) && $stable(dir_up)));

    // R9
    dir_set_chk: assert property (@(posedge clk) disable iff (rst)
        up |=> dir_up);

    // R9
    dir_clr_chk: assert property (@(posedge clk) disable iff (rst)
        dn |=> !dir_up);

    // R11
    match_val_chk: assert property (@(posedge clk) disable iff (rst)
        match |-> count == $past(cmp));

    // R11
    match_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!up && !dn) |=> !match);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: rtl/quad_enc_counter.sv
`timescale 1ns/1ps
module quad_enc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic [1:0]       mode,
    input  logic [1:0]       a_edge_sel,
    input  logic [1:0]       b_edge_sel,
    input  logic             clr_mode,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             match,
    output logic             enc_err
);

    localparam int NPH = 2;

    logic [NPH-1:0] pins;
    phase_t         ph [NPH];
    logic           step_up, step_dn, bad_step;

    assign pins = {enc_b, enc_a};

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        qenc_phase_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .pin (pins[g]),
            .ph  (ph[g])
        );
    end

    qenc_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .mode     (qmode_e'(mode)),
        .a_sel    (edge_sel_e'(a_edge_sel)),
        .b_sel    (edge_sel_e'(b_edge_sel)),
        .pa       (ph[0]),
        .pb       (ph[1]),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .bad_step (bad_step)
    );

    qenc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .up     (step_up),
        .dn     (step_dn),
        .bad    (bad_step),
        .clr_en (clr_mode),
        .cmp    (cmp_val),
        .count  (count),
        .dir_up (dir_up),
        .match  (match),
        .err    (enc_err)
    );

endmodule

// File: tb/quad_enc_counter_test.sv
`timescale 1ns/1ps
module quad_enc_counter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic [1:0]  mode = 2'd0, a_edge_sel = 2'd3, b_edge_sel = 2'd3;
    logic        clr_mode = 1'b0;
    logic [15:0] cmp_val = 16'h0;
    logic [15:0] count;
    logic        dir_up, match, enc_err;

    always #4 clk = ~clk;

    quad_enc_counter uut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .mode(mode),
        .a_edge_sel(a_edge_sel), .b_edge_sel(b_edge_sel), .clr_mode(clr_mode),
        .cmp_val(cmp_val), .count(count), .dir_up(dir_up), .match(match),
        .enc_err(enc_err)
    );

    typedef struct {
        logic [15:0] cnt;
        logic        dir;
        logic        mt;
        logic        er;
        string       req;
    } exp_t;

    exp_t q[$];
    event sample_ev;
    int   total = 0, bad = 0;
    bit   done = 0;

    // reference state
    logic [15:0] m_cnt;
    logic        m_dir, m_err, m_a, m_b;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor: pops and compares as results appear
    initial forever begin
        @(sample_ev);
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(count === e.cnt, e.req, "count", int'(count), int'(e.cnt));
            check(dir_up === e.dir, e.req, "dir_up", int'(dir_up), int'(e.dir));
            check(match === e.mt, e.req, "match", int'(match), int'(e.mt));
            check(enc_err === e.er, e.req, "enc_err", int'(enc_err), int'(e.er));
        end
    end

    function automatic logic sel_ok(input logic [1:0] sel, input logic r, input logic f);
        return (sel == 2'd1 && r) || (sel == 2'd2 && f) || (sel == 2'd3 && (r || f));
    endfunction

    task automatic push_exp(input logic mt, input string req);
        exp_t e;
        e.cnt = m_cnt; e.dir = m_dir; e.mt = mt; e.er = m_err; e.req = req;
        q.push_back(e);
        -> sample_ev;
    endtask

    // driver: apply a phase pair, predict, push
    task automatic apply(input logic na, input logic nb, input string req);
        logic ar, af, br, bf, up, dn, ill;
        @(negedge clk);
        enc_a = na; enc_b = nb;
        ar = na & ~m_a; af = ~na & m_a;
        br = nb & ~m_b; bf = ~nb & m_b;
        up = 0; dn = 0; ill = 0;
        case (mode)
            2'd0: begin
                if (sel_ok(a_edge_sel, ar, af)) begin up = ~nb; dn = nb; end
            end
            2'd1: begin
                up = sel_ok(a_edge_sel, ar, af);
                dn = sel_ok(b_edge_sel, br, bf);
                if (up && dn) begin up = 0; dn = 0; end
            end
            2'd2: begin
                if (!nb) begin up = ar; dn = af; end
            end
            default: begin
                case ({m_a, m_b, na, nb})
                    4'b0010, 4'b1011, 4'b1101, 4'b0100: up = 1;
                    4'b1000, 4'b1110, 4'b0111, 4'b0001: dn = 1;
                    4'b0011, 4'b1100, 4'b1001, 4'b0110: ill = 1;
                    default: ;
                endcase
            end
        endcase
        if (up) begin m_cnt = m_cnt + 16'd1; m_dir = 1; end
        else if (dn) begin
            m_cnt = (clr_mode && m_cnt == cmp_val) ? 16'd0 : m_cnt - 16'd1;
            m_dir = 0;
        end
        if (ill) m_err = 1;
        m_a = na; m_b = nb;
        repeat (3) @(negedge clk);
        push_exp((up || dn) && (m_cnt == cmp_val), req);
    endtask

    task automatic cfg(input logic [1:0] md, input logic [1:0] as, input logic [1:0] bs,
                       input logic cl, input logic [15:0] cv);
        @(negedge clk);
        mode = md; a_edge_sel = as; b_edge_sel = bs; clr_mode = cl; cmp_val = cv;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; enc_a = 0; enc_b = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        m_cnt = 0; m_dir = 0; m_err = 0; m_a = 0; m_b = 0;
        repeat (4) @(negedge clk);
        push_exp(1'b0, "R12");
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cfg(2'd0, 2'd3, 2'd3, 1'b0, 16'h0100);
        do_reset();
        // R1: latency, single event per transition (count moves at 3rd edge)
        @(negedge clk); enc_a = 1;
        repeat (2) @(negedge clk);
        check(count === 16'h0, "R1", "count before 3rd edge", int'(count), 0);
        @(negedge clk);
        check(count === 16'h1, "R1", "count at 3rd edge", int'(count), 1);
        repeat (4) @(negedge clk);
        check(count === 16'h1, "R1", "count after hold", int'(count), 1);
        m_cnt = 16'h1; m_dir = 1; m_a = 1;
        // R2: mode 0
        apply(0, 0, "R2");        // A fall, B low -> up
        apply(0, 1, "R2");        // B edge only -> none
        apply(1, 1, "R2");        // A rise, B high -> down
        apply(0, 1, "R2");        // A fall, B high -> down
        // R7: rising only
        cfg(2'd0, 2'd1, 2'd3, 1'b0, 16'h0100);
        apply(1, 1, "R7");
        apply(0, 1, "R7");        // fall ignored
        cfg(2'd0, 2'd0, 2'd3, 1'b0, 16'h0100);
        apply(1, 1, "R7");        // no edge selected
        // R3: mode 1
        cfg(2'd1, 2'd3, 2'd3, 1'b0, 16'h0100);
        apply(0, 1, "R3");        // A up
        apply(0, 0, "R3");        // B down
        apply(1, 1, "R3");        // both -> cancel
        cfg(2'd1, 2'd3, 2'd2, 1'b0, 16'h0100);
        apply(1, 0, "R7");        // B fall counts down
        apply(1, 1, "R7");        // B rise ignored
        // R4: mode 2, selections ignored
        cfg(2'd2, 2'd0, 2'd0, 1'b0, 16'h0100);
        apply(1, 0, "R4");        // B fall: none
        apply(0, 0, "R4");        // A fall, B low -> down
        apply(1, 0, "R4");        // A rise -> up
        apply(1, 1, "R4");
        apply(0, 1, "R4");        // gated
        apply(1, 1, "R4");        // gated
        // R5/R6: mode 3 with selections off
        do_reset();
        cfg(2'd3, 2'd0, 2'd0, 1'b0, 16'h0100);
        apply(1, 0, "R5"); apply(1, 1, "R5"); apply(0, 1, "R5"); apply(0, 0, "R5");
        apply(0, 1, "R5"); apply(1, 1, "R5"); apply(1, 0, "R5"); apply(0, 0, "R5");
        apply(1, 1, "R6");        // illegal
        apply(0, 1, "R6");        // up, error stays
        apply(1, 0, "R6");        // illegal again
        // R8: wrap
        do_reset();
        cfg(2'd1, 2'd3, 2'd3, 1'b0, 16'h0100);
        apply(0, 1, "R8");        // 0 -> FFFF
        apply(1, 1, "R8");        // FFFF -> 0
        apply(1, 0, "R9");
        // R10/R11: clear on match
        do_reset();
        cfg(2'd1, 2'd3, 2'd3, 1'b1, 16'h0003);
        apply(1, 0, "R11"); apply(0, 0, "R11"); apply(1, 0, "R11");
        apply(1, 1, "R10");       // down at compare -> 0
        cfg(2'd1, 2'd3, 2'd3, 1'b0, 16'h0003);
        apply(0, 1, "R11"); apply(1, 1, "R11"); apply(0, 1, "R11");
        apply(0, 0, "R10");       // no clear -> 2
        apply(0, 0, "R11");       // no event, no pulse
        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule